// File: doc/BRIEF.md
# Auxiliary External-Data Access Mapper

This block sits between an 8-bit core's external-data (MOVX-style) access path and the places that data can live. For every access strobe it decides whether the access goes to a 512-byte on-chip auxiliary RAM, to a 128-byte on-chip EEPROM window, or out to the external bus. It then drives exactly one destination select for one cycle.

An access uses one of two address forms. The first is a full 16-bit pointer. The second is an 8-bit pointer whose upper byte comes from a page-select value. With the 8-bit form, page values 00h and 01h pick the lower and upper halves of the auxiliary RAM, and page 02h reaches the EEPROM. The core's control logic supplies two enable bits, one for the auxiliary RAM and one for the EEPROM. Both are expected to be cleared at chip reset.

The external address/data port and the high-address port follow the address only on external accesses. Across internal accesses they keep whatever they last showed.

Top module: `xram_access_mapper`

## Requirements
- R1: With `aux_en_i` high, a 16-bit-pointer access to 0000h..01FFh asserts `aux_sel_o` with `aux_addr_o` equal to the low 9 address bits. With `aux_en_i` low, `aux_sel_o` never follows a strobe.
- R2: With `aux_en_i` high, an 8-bit-pointer access with page 00h or 01h asserts `aux_sel_o` with `aux_addr_o` = {page bit 0, pointer}.
- R3: The access goes to the external bus (`ext_req_o` high, `ext_addr_o` = effective address) when no internal region matches. This covers 16-bit addresses of 0200h and above outside the EEPROM window, 8-bit pages other than 00h..02h, and any access whose region is disabled. For 8-bit accesses the effective address is {page, pointer}.
- R4: `port_lo_o`/`port_hi_o` load the low/high bytes of the effective address on an external access and hold unchanged on internal accesses and idle cycles.
- R5: With `eep_en_i` high, a 16-bit-pointer access to FF80h..FFFFh asserts `eep_sel_o` with `eep_addr_o` equal to the low 7 address bits.
- R6: With `eep_en_i` high, an 8-bit-pointer access with page 02h asserts `eep_sel_o` with `eep_addr_o` equal to the low 7 pointer bits.
- R7: Each strobe raises exactly one of `aux_sel_o`, `eep_sel_o`, `ext_req_o`. If both the EEPROM and auxiliary decodes match, the EEPROM wins.
- R8: The selects rise in the cycle after the strobe edge and last exactly one cycle per strobe. Strobes on consecutive cycles give consecutive one-cycle selects, and with no strobe all selects are low.
- R9: `mem_we_o` and `mem_wdata_o` carry the strobe's write flag and write data alongside the select.
- R10: While `rst_ni` is low, all selects and `mem_we_o` are low and both port outputs read FFh.
- R11: With `eep_en_i` low, an access that would hit the EEPROM window (16-bit FF80h..FFFFh or 8-bit page 02h) goes to the external bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_strobe_i | input | 1 | One access per cycle it is high |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_indirect_i | input | 1 | 1 = 8-bit pointer form, 0 = 16-bit pointer form |
| dptr_i | input | 16 | 16-bit pointer address |
| ptr8_i | input | 8 | 8-bit pointer address |
| wdata_i | input | 8 | Write data |
| aux_en_i | input | 1 | Auxiliary RAM enable |
| eep_en_i | input | 1 | EEPROM window enable |
| page_sel_i | input | 8 | Page-select value for 8-bit pointer accesses |
| aux_sel_o | output | 1 | Auxiliary RAM select, one cycle |
| aux_addr_o | output | 9 | Auxiliary RAM byte address |
| eep_sel_o | output | 1 | EEPROM select, one cycle |
| eep_addr_o | output | 7 | EEPROM byte address |
| ext_req_o | output | 1 | External bus request, one cycle |
| ext_addr_o | output | 16 | External bus address |
| mem_we_o | output | 1 | Write flag of the current access |
| mem_wdata_o | output | 8 | Write data of the current access |
| port_lo_o | output | 8 | Address/data port value, held across internal accesses |
| port_hi_o | output | 8 | High-address port value, held across internal accesses |

## Verification
Two functions can land in the same cycle: the one-cycle clearing of a select and the capture of a new strobe, and, alongside them, the port-hold path and the port-load path. The bench drives strobes on consecutive cycles that alternate between internal and external destinations, and changes the enables and page between them. A behavioural model recomputes the route, the selects and the held port bytes at every edge, and each of those is compared on every falling edge.

// File: rtl/xmap_pkg.sv
package xmap_pkg;
  typedef enum logic [1:0] {
    DEST_NONE = 2'd0,
    DEST_AUX  = 2'd1,
    DEST_EEP  = 2'd2,
    DEST_EXT  = 2'd3
  } dest_e;

  typedef struct packed {
    dest_e       dest;
    logic [15:0] addr;
  } route_t;
endpackage

// File: rtl/xmap_addr_decode.sv
module xmap_addr_decode
  import xmap_pkg::*;
#(
  parameter int         AUX_BYTES = 512,
  parameter int         EEP_BYTES = 128,
  parameter logic [7:0] EEP_PAGE  = 8'h02
) (
  input  logic        indirect_i,
  input  logic [15:0] dptr_i,
  input  logic [7:0]  ptr8_i,
  input  logic [7:0]  page_i,
  input  logic        aux_en_i,
  input  logic        eep_en_i,
  output route_t      route_o
);
  localparam logic [7:0]  AUX_PAGES = 8'(AUX_BYTES / 256);
  localparam logic [16:0] AUX_LIM   = 17'(AUX_BYTES);
  localparam logic [16:0] EEP_BASE  = 17'(32'h1_0000 - EEP_BYTES);

  logic aux_hit, eep_hit;

  always_comb begin
    if (indirect_i) begin
      eep_hit = eep_en_i && (page_i == EEP_PAGE);
      aux_hit = aux_en_i && (page_i < AUX_PAGES);
      route_o.addr = {page_i, ptr8_i};
    end else begin
      eep_hit = eep_en_i && ({1'b0, dptr_i} >= EEP_BASE);
      aux_hit = aux_en_i && ({1'b0, dptr_i} < AUX_LIM);
      route_o.addr = dptr_i;
    end
    // EEPROM decode has priority over the auxiliary RAM
    if (eep_hit)      route_o.dest = DEST_EEP;
    else if (aux_hit) route_o.dest = DEST_AUX;
    else              route_o.dest = DEST_EXT;
  end
endmodule

// File: rtl/xmap_sel_reg.sv
module xmap_sel_reg
  import xmap_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        strobe_i,
  input  logic        write_i,
  input  logic [7:0]  wdata_i,
  input  route_t      route_i,
  output dest_e       dest_o,
  output logic [15:0] addr_o,
  output logic        we_o,
  output logic [7:0]  wdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dest_o  <= DEST_NONE;
      addr_o  <= '0;
      we_o    <= 1'b0;
      wdata_o <= '0;
    end else if (strobe_i) begin
      dest_o  <= route_i.dest;
      addr_o  <= route_i.addr;
      we_o    <= write_i;
      wdata_o <= wdata_i;
    end else begin
      dest_o  <= DEST_NONE;
      we_o    <= 1'b0;
    end
  end

  // R8
  idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> (dest_o == DEST_NONE && !we_o));
  // R8
  strobe_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> (dest_o != DEST_NONE));
endmodule

// File: rtl/xmap_port_hold.sv
module xmap_port_hold (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [15:0] addr_i,
  output logic [7:0]  port_lo_o,
  output logic [7:0]  port_hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_lo_o <= 8'hFF;
      port_hi_o <= 8'hFF;
    end else if (load_i) begin
      port_lo_o <= addr_i[7:0];
      port_hi_o <= addr_i[15:8];
    end
  end

  // R4
  port_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(port_lo_o) && $stable(port_hi_o)));
endmodule

// File: rtl/xram_access_mapper.sv
module xram_access_mapper
  import xmap_pkg::*;
#(
  parameter int         AUX_BYTES = 512,
  parameter int         EEP_BYTES = 128,
  parameter logic [7:0] EEP_PAGE  = 8'h02,
  localparam int        AUX_AW    = $clog2(AUX_BYTES),
  localparam int        EEP_AW    = $clog2(EEP_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_strobe_i,
  input  logic              acc_write_i,
  input  logic              acc_indirect_i,
  input  logic [15:0]       dptr_i,
  input  logic [7:0]        ptr8_i,
  input  logic [7:0]        wdata_i,
  input  logic              aux_en_i,
  input  logic              eep_en_i,
  input  logic [7:0]        page_sel_i,
  output logic              aux_sel_o,
  output logic [AUX_AW-1:0] aux_addr_o,
  output logic              eep_sel_o,
  output logic [EEP_AW-1:0] eep_addr_o,
  output logic              ext_req_o,
  output logic [15:0]       ext_addr_o,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o,
  output logic [7:0]        port_lo_o,
  output logic [7:0]        port_hi_o
);
  route_t      route;
  dest_e       dest_q;
  logic [15:0] addr_q;

  xmap_addr_decode #(
    .AUX_BYTES(AUX_BYTES),
    .EEP_BYTES(EEP_BYTES),
    .EEP_PAGE (EEP_PAGE)
  ) u_decode (
    .indirect_i(acc_indirect_i),
    .dptr_i    (dptr_i),
    .ptr8_i    (ptr8_i),
    .page_i    (page_sel_i),
    .aux_en_i  (aux_en_i),
    .eep_en_i  (eep_en_i),
    .route_o   (route)
  );

  xmap_sel_reg u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(acc_strobe_i),
    .write_i (acc_write_i),
    .wdata_i (wdata_i),
    .route_i (route),
    .dest_o  (dest_q),
    .addr_o  (addr_q),
    .we_o    (mem_we_o),
    .wdata_o (mem_wdata_o)
  );

  xmap_port_hold u_ports (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (acc_strobe_i && route.dest == DEST_EXT),
    .addr_i   (route.addr),
    .port_lo_o(port_lo_o),
    .port_hi_o(port_hi_o)
  );

  assign aux_sel_o  = (dest_q == DEST_AUX);
  assign eep_sel_o  = (dest_q == DEST_EEP);
  assign ext_req_o  = (dest_q == DEST_EXT);
  assign aux_addr_o = addr_q[AUX_AW-1:0];
  assign eep_addr_o = addr_q[EEP_AW-1:0];
  assign ext_addr_o = addr_q;

  // R7
  one_dest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({aux_sel_o, eep_sel_o, ext_req_o}));
  // R1
  aux_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_strobe_i && !aux_en_i) |=> !aux_sel_o);
  // R11
  eep_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_strobe_i && !eep_en_i) |=> !eep_sel_o);
  // R9
  we_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_strobe_i |=> (mem_we_o == $past(acc_write_i)));
  // R4
  port_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_req_o |-> ({port_hi_o, port_lo_o} == ext_addr_o));
endmodule

// File: tb/xram_access_mapper_tb.sv
module xram_access_mapper_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_strobe_i = 1'b0, acc_write_i = 1'b0, acc_indirect_i = 1'b0;
  logic [15:0] dptr_i = '0;
  logic [7:0]  ptr8_i = '0, wdata_i = '0, page_sel_i = '0;
  logic        aux_en_i = 1'b0, eep_en_i = 1'b0;
  logic        aux_sel_o, eep_sel_o, ext_req_o, mem_we_o;
  logic [8:0]  aux_addr_o;
  logic [6:0]  eep_addr_o;
  logic [15:0] ext_addr_o;
  logic [7:0]  mem_wdata_o, port_lo_o, port_hi_o;

  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  xram_access_mapper u_dut (
    .clk_i, .rst_ni, .acc_strobe_i, .acc_write_i, .acc_indirect_i,
    .dptr_i, .ptr8_i, .wdata_i, .aux_en_i, .eep_en_i, .page_sel_i,
    .aux_sel_o, .aux_addr_o, .eep_sel_o, .eep_addr_o, .ext_req_o,
    .ext_addr_o, .mem_we_o, .mem_wdata_o, .port_lo_o, .port_hi_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: route chosen from addresses, not from decode structure
  int    m_dest;  // 0 none, 1 aux, 2 eep, 3 ext
  int    m_addr, m_we, m_wd, m_lo, m_hi;
  string m_tag;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_dest = 0; m_we = 0; m_wd = 0; m_lo = 255; m_hi = 255; m_tag = "R10";
    end else if (acc_strobe_i) begin
      int ea;
      ea = acc_indirect_i ? (int'(page_sel_i) * 256 + int'(ptr8_i)) : int'(dptr_i);
      m_addr = ea; m_we = int'(acc_write_i);
      m_wd = int'(wdata_i);
      if (acc_indirect_i) begin
        if (eep_en_i && page_sel_i == 8'd2)      begin m_dest = 2; m_tag = "R6"; end
        else if (aux_en_i && page_sel_i < 8'd2)  begin m_dest = 1; m_tag = "R2"; end
        else begin m_dest = 3; m_tag = (page_sel_i == 8'd2) ? "R11" : "R3"; end
      end else begin
        if (eep_en_i && ea >= 16'hFF80)          begin m_dest = 2; m_tag = "R5"; end
        else if (aux_en_i && ea < 512)           begin m_dest = 1; m_tag = "R1"; end
        else begin m_dest = 3; m_tag = (ea >= 16'hFF80) ? "R11" : "R3"; end
      end
      if (m_dest == 3) begin m_lo = ea % 256; m_hi = ea / 256; end
    end else begin
      m_dest = 0; m_we = 0; m_tag = "R8";
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      check({aux_sel_o, eep_sel_o, ext_req_o} ==
            {m_dest == 1, m_dest == 2, m_dest == 3}, m_tag,
            {aux_sel_o, eep_sel_o, ext_req_o},
            {m_dest == 1, m_dest == 2, m_dest == 3});
      check($countones({aux_sel_o, eep_sel_o, ext_req_o}) == (m_dest != 0 ? 1 : 0), "R7",
            $countones({aux_sel_o, eep_sel_o, ext_req_o}), (m_dest != 0 ? 1 : 0));
      if (m_dest == 1) check(int'(aux_addr_o) == m_addr % 512, m_tag, aux_addr_o, m_addr % 512);
      if (m_dest == 2) check(int'(eep_addr_o) == m_addr % 128, m_tag, eep_addr_o, m_addr % 128);
      if (m_dest == 3) check(int'(ext_addr_o) == m_addr, m_tag, ext_addr_o, m_addr);
      check(int'(mem_we_o) == m_we, "R9", mem_we_o, m_we);
      if (m_dest != 0) check(int'(mem_wdata_o) == m_wd, "R9", mem_wdata_o, m_wd);
      check({port_hi_o, port_lo_o} == 16'(m_hi * 256 + m_lo), "R4",
            {port_hi_o, port_lo_o}, m_hi * 256 + m_lo);
    end
  end

  task automatic cfg(input bit aux, input bit eep, input int page);
    @(negedge clk_i);
    aux_en_i = aux; eep_en_i = eep; page_sel_i = 8'(page); acc_strobe_i = 1'b0;
  endtask

  // Leaves the strobe high; consecutive calls make back-to-back accesses
  task automatic acc(input bit ind, input int addr, input bit wr, input int wd);
    @(negedge clk_i);
    acc_strobe_i = 1'b1; acc_indirect_i = ind; acc_write_i = wr;
    wdata_i = 8'(wd);
    if (ind) ptr8_i = 8'(addr); else dptr_i = 16'(addr);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk_i); acc_strobe_i = 1'b0; end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R10 reset state
    check({aux_sel_o, eep_sel_o, ext_req_o, mem_we_o} == 4'b0, "R10",
          {aux_sel_o, eep_sel_o, ext_req_o, mem_we_o}, 0);
    check({port_hi_o, port_lo_o} == 16'hFFFF, "R10", {port_hi_o, port_lo_o}, 16'hFFFF);
    rst_ni = 1'b1;
    idle(2);
    // R3/R1: disabled then enabled aux RAM
    cfg(0, 0, 0); acc(0, 16'h0010, 0, 0); idle(1);
    cfg(1, 0, 0); acc(0, 16'h0123, 1, 8'hA5); acc(0, 16'h01FF, 0, 0);
    acc(0, 16'h0200, 1, 8'h3C); idle(2);
    // R2: 8-bit pointer pages
    cfg(1, 0, 0); acc(1, 8'h34, 1, 8'h11); idle(1);
    cfg(1, 0, 1); acc(1, 8'hFF, 0, 0); idle(1);
    cfg(1, 0, 3); acc(1, 8'h56, 0, 0); idle(1);
    // R5/R6: EEPROM window
    cfg(1, 1, 2); acc(0, 16'hFF80, 1, 8'h77); acc(0, 16'hFFFF, 0, 0);
    acc(0, 16'hFF7F, 0, 0); acc(1, 8'h85, 1, 8'h99); acc(0, 16'h0040, 0, 0); idle(2);
    // R11: EEPROM disabled
    cfg(1, 0, 2); acc(0, 16'hFF90, 0, 0); acc(1, 8'h12, 1, 8'h22); idle(2);
    // R8/R4: back-to-back internal/external mixes
    cfg(1, 1, 0);
    acc(0, 16'h0005, 0, 0); acc(0, 16'h8001, 1, 8'h44); acc(0, 16'hFFC0, 0, 0);
    acc(1, 8'h9A, 0, 0); acc(0, 16'h1234, 0, 0); idle(3);
    // Random mix
    for (int i = 0; i < 300; i++) begin
      cfg(1'($urandom), 1'($urandom), int'($urandom % 4));
      for (int j = 0; j < 3; j++) begin
        int r;
        r = int'($urandom % 4);
        if (r == 0)      acc(0, int'($urandom % 1024), 1'($urandom), int'($urandom % 256));
        else if (r == 1) acc(0, 16'hFF00 + int'($urandom % 256), 1'($urandom), int'($urandom % 256));
        else if (r == 2) acc(0, int'($urandom % 65536), 1'($urandom), int'($urandom % 256));
        else             acc(1, int'($urandom % 256), 1'($urandom), int'($urandom % 256));
      end
      idle(int'($urandom % 2) + 1);
    end
    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule